// File: doc/BRIEF.md
# Stereo Serial Audio Receiver

This block turns a serial audio stream, carried on a bit clock, a word clock and one data line, into stereo sample pairs for a system-side sample FIFO. The word clock is low during the left slot and high during the right slot. Bits are sampled on the rising bit-clock edge and collected in two separate shift registers, one for each channel. Each finished word is copied into a holding register at the word-clock transition that ends it. When the right word of a frame is complete, the pair is passed to the system clock domain and announced by a one-cycle strobe.

The system side sets a controller enable, a channel enable and the format options. The options are the first-bit position (one bit clock after the word-clock edge, or on the edge itself), the word length, where the word sits inside the output register, and whether the first received bit is the most or least significant. Once enabled, the receiver waits for the next start of a left word before it collects any data. Format options are expected to change only while the channel is disabled.

Top module: `stereo_serial_rx`

## Requirements
- R1: While `glb_en` is low, no pair is produced, whatever `chan_en` and the serial lines do.
- R2: After the enables rise, collection starts only at the next right-to-left word-clock transition (word clock falling). Bits of any partly received frame before that point never reach the outputs.
- R3: Bits sampled while the word clock is low form the left word and appear on `left_data`. Bits sampled while it is high form the right word and appear on `right_data`.
- R4: Each complete frame gives exactly one `pair_valid` pulse of one system clock. In that same cycle `left_data` and `right_data` carry the frame's pair, and they hold their values in every cycle without a pulse.
- R5: With `fmt_delay`=1 the first bit of a word is the one sampled one bit clock after the word-clock change. With `fmt_delay`=0 it is the bit sampled on the edge where the change is first seen.
- R6: `word_len` selects 16 (0), 20 (1), 24 (2) or 32 (3) bits per word. Bits received after that many in a slot are discarded.
- R7: With `fmt_rjust`=1 the word fills the low bits of the 32-bit output and the upper bits are zero. With `fmt_rjust`=0 it fills the high bits and the lower bits are zero.
- R8: With `fmt_lsb_first`=0 the first received bit is the word's most significant bit. With `fmt_lsb_first`=1 it is the least significant bit.
- R9: Clearing `chan_en` returns the receiver to waiting for a left boundary and clears both shift registers. A frame interrupted this way produces no pair.
- R10: After reset, `pair_valid` is low and both data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low asynchronous reset for both domains |
| glb_en | input | 1 | Controller enable |
| chan_en | input | 1 | Receive channel enable |
| fmt_delay | input | 1 | 1: first bit one bit clock after the word-clock edge |
| fmt_rjust | input | 1 | 1: word placed in the low bits of the output |
| fmt_lsb_first | input | 1 | 1: least significant bit arrives first |
| word_len | input | 2 | Word length code: 0=16, 1=20, 2=24, 3=32 |
| bclk | input | 1 | Serial bit clock |
| wclk | input | 1 | Word clock, low for left, high for right |
| sdata | input | 1 | Serial data |
| left_data | output | DATA_W | Left word of the latest pair |
| right_data | output | DATA_W | Right word of the latest pair |
| pair_valid | output | 1 | One-cycle strobe for a new pair |

## Verification
At a word boundary, a single bit-clock edge copies the finished word into its holding register and also loads the first bit of the next word into the other shift register. In the non-delayed format that first bit is exactly the bit sampled at the edge where the word-clock change is seen. The bench provokes this by forcing the leading bit of the first frame in each run to one, so both the most and the least significant bits are set. Any slip by one bit shows up as a wrong end bit in the pair that the cycle-by-cycle model compares.

// File: rtl/stereo_rx_pkg.sv
package stereo_rx_pkg;

   typedef enum logic [1:0] {
      WLEN_16 = 2'd0,
      WLEN_20 = 2'd1,
      WLEN_24 = 2'd2,
      WLEN_32 = 2'd3
   } srx_wlen_e;

   typedef enum logic {
      RX_WAIT = 1'b0,
      RX_RUN  = 1'b1
   } srx_state_e;

   localparam int unsigned SRX_MAX_WORD = 32;

   function automatic int unsigned wlen_bits(input srx_wlen_e w);
      case (w)
         WLEN_16: return 16;
         WLEN_20: return 20;
         WLEN_24: return 24;
         default: return 32;
      endcase
   endfunction

endpackage

// File: rtl/srx_sync_bit.sv
module srx_sync_bit #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic chain [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("srx_sync_bit: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/srx_deserializer.sv
module srx_deserializer
   import stereo_rx_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              bclk,
   input  logic              b_rst_n,
   input  logic              en_b,
   input  logic              fmt_delay,
   input  logic              fmt_rjust,
   input  logic              fmt_lsb_first,
   input  srx_wlen_e         wlen,
   input  logic              wclk,
   input  logic              sdata,
   output logic [DATA_W-1:0] left_hold,
   output logic [DATA_W-1:0] right_hold,
   output logic              pair_tgl,
   output logic              running,
   output logic              sr_empty
);

   localparam int CNT_W = $clog2(DATA_W + 1);

   srx_state_e        state;
   logic [DATA_W-1:0] left_sr;
   logic [DATA_W-1:0] right_sr;
   logic [CNT_W-1:0]  bit_cnt;
   logic              wclk_q;
   logic              wclk_qq;
   logic              eff_ch;
   logic              prev_ch;
   logic              boundary;
   logic [CNT_W-1:0]  word_bits;
   int unsigned       pad_bits;
   logic [DATA_W-1:0] first_word;

   // Shift one bit into a word, direction chosen by format.
   function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] sr,
                                                  input logic b,
                                                  input logic lsb);
      if (lsb) return {b, sr[DATA_W-1:1]};
      else     return {sr[DATA_W-2:0], b};
   endfunction

   // Move the collected word to its place in the output register.
   function automatic logic [DATA_W-1:0] place(input logic [DATA_W-1:0] sr,
                                               input int unsigned sh,
                                               input logic lsb,
                                               input logic rj);
      if (lsb) return rj ? (sr >> sh) : sr;
      else     return rj ? sr : (sr << sh);
   endfunction

   // Word-clock history for boundary detection in both formats.
   always_ff @(posedge bclk or negedge b_rst_n) begin
      if (!b_rst_n) begin
         wclk_q  <= 1'b0;
         wclk_qq <= 1'b0;
      end else begin
         wclk_q  <= wclk;
         wclk_qq <= wclk_q;
      end
   end

   // In the delayed format the channel seen by the data lags one bit clock.
   assign eff_ch     = fmt_delay ? wclk_q  : wclk;
   assign prev_ch    = fmt_delay ? wclk_qq : wclk_q;
   assign boundary   = eff_ch != prev_ch;
   assign word_bits  = CNT_W'(wlen_bits(wlen));
   assign pad_bits   = DATA_W - wlen_bits(wlen);
   assign first_word = shift_in('0, sdata, fmt_lsb_first);
   assign running    = state == RX_RUN;
   assign sr_empty   = (left_sr == '0) && (right_sr == '0);

   always_ff @(posedge bclk or negedge b_rst_n) begin
      if (!b_rst_n) begin
         state      <= RX_WAIT;
         left_sr    <= '0;
         right_sr   <= '0;
         bit_cnt    <= '0;
         left_hold  <= '0;
         right_hold <= '0;
         pair_tgl   <= 1'b0;
      end else if (!en_b) begin
         state    <= RX_WAIT;
         left_sr  <= '0;
         right_sr <= '0;
         bit_cnt  <= '0;
      end else begin
         case (state)
            RX_WAIT: begin
               if (boundary && !eff_ch) begin
                  state    <= RX_RUN;
                  left_sr  <= first_word;
                  right_sr <= '0;
                  bit_cnt  <= CNT_W'(1);
               end
            end
            default: begin
               if (boundary) begin
                  bit_cnt <= CNT_W'(1);
                  if (eff_ch) begin
                     left_hold <= place(left_sr, pad_bits, fmt_lsb_first, fmt_rjust);
                     right_sr  <= first_word;
                  end else begin
                     right_hold <= place(right_sr, pad_bits, fmt_lsb_first, fmt_rjust);
                     pair_tgl   <= ~pair_tgl;
                     left_sr    <= first_word;
                  end
               end else if (bit_cnt < word_bits) begin
                  bit_cnt <= bit_cnt + CNT_W'(1);
                  if (eff_ch) right_sr <= shift_in(right_sr, sdata, fmt_lsb_first);
                  else        left_sr  <= shift_in(left_sr,  sdata, fmt_lsb_first);
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/srx_pair_cdc.sv
module srx_pair_cdc #(
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              sys_clk,
   input  logic              sys_rst_n,
   input  logic              pair_tgl,
   input  logic [DATA_W-1:0] left_hold,
   input  logic [DATA_W-1:0] right_hold,
   output logic [DATA_W-1:0] left_data,
   output logic [DATA_W-1:0] right_data,
   output logic              pair_valid
);

   logic tgl_s;
   logic tgl_seen;
   logic tgl_edge;

   srx_sync_bit #(.STAGES(SYNC_STAGES)) i_tgl_sync (
      .clk   (sys_clk),
      .rst_n (sys_rst_n),
      .d     (pair_tgl),
      .q     (tgl_s)
   );

   assign tgl_edge = tgl_s ^ tgl_seen;

   // Holding registers are stable for half a frame after the toggle flips.
   always_ff @(posedge sys_clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         tgl_seen   <= 1'b0;
         pair_valid <= 1'b0;
         left_data  <= '0;
         right_data <= '0;
      end else begin
         tgl_seen   <= tgl_s;
         pair_valid <= tgl_edge;
         if (tgl_edge) begin
            left_data  <= left_hold;
            right_data <= right_hold;
         end
      end
   end

endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx
   import stereo_rx_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              sys_clk,
   input  logic              sys_rst_n,
   input  logic              glb_en,
   input  logic              chan_en,
   input  logic              fmt_delay,
   input  logic              fmt_rjust,
   input  logic              fmt_lsb_first,
   input  logic [1:0]        word_len,
   input  logic              bclk,
   input  logic              wclk,
   input  logic              sdata,
   output logic [DATA_W-1:0] left_data,
   output logic [DATA_W-1:0] right_data,
   output logic              pair_valid
);

   if (DATA_W < SRX_MAX_WORD) begin : g_bad_width
      $error("stereo_serial_rx: DATA_W must hold the longest word");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("stereo_serial_rx: SYNC_STAGES must be at least 2");
   end

   logic              en_sys_q;
   logic              b_rst_n;
   logic              en_b;
   logic [DATA_W-1:0] left_hold;
   logic [DATA_W-1:0] right_hold;
   logic              pair_tgl;
   logic              running;
   logic              sr_empty;

   always_ff @(posedge sys_clk or negedge sys_rst_n) begin
      if (!sys_rst_n) en_sys_q <= 1'b0;
      else            en_sys_q <= glb_en & chan_en;
   end

   srx_sync_bit #(.STAGES(SYNC_STAGES)) i_brst_sync (
      .clk   (bclk),
      .rst_n (sys_rst_n),
      .d     (1'b1),
      .q     (b_rst_n)
   );

   srx_sync_bit #(.STAGES(SYNC_STAGES)) i_en_sync (
      .clk   (bclk),
      .rst_n (b_rst_n),
      .d     (en_sys_q),
      .q     (en_b)
   );

   srx_deserializer #(.DATA_W(DATA_W)) i_deser (
      .bclk          (bclk),
      .b_rst_n       (b_rst_n),
      .en_b          (en_b),
      .fmt_delay     (fmt_delay),
      .fmt_rjust     (fmt_rjust),
      .fmt_lsb_first (fmt_lsb_first),
      .wlen          (srx_wlen_e'(word_len)),
      .wclk          (wclk),
      .sdata         (sdata),
      .left_hold     (left_hold),
      .right_hold    (right_hold),
      .pair_tgl      (pair_tgl),
      .running       (running),
      .sr_empty      (sr_empty)
   );

   srx_pair_cdc #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_cdc (
      .sys_clk    (sys_clk),
      .sys_rst_n  (sys_rst_n),
      .pair_tgl   (pair_tgl),
      .left_hold  (left_hold),
      .right_hold (right_hold),
      .left_data  (left_data),
      .right_data (right_data),
      .pair_valid (pair_valid)
   );

endmodule

// File: rtl/stereo_serial_rx_chk.sv
module stereo_serial_rx_chk #(
   parameter int DATA_W = 32
) (
   input logic              sys_clk,
   input logic              sys_rst_n,
   input logic              bclk,
   input logic              b_rst_n,
   input logic              en_b,
   input logic              running,
   input logic              pair_tgl,
   input logic              sr_empty,
   input logic              pair_valid,
   input logic [DATA_W-1:0] left_data,
   input logic [DATA_W-1:0] right_data
);

   AST_PULSE_SINGLE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      pair_valid |=> !pair_valid); // R4

   AST_DATA_HELD: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      !pair_valid |-> ($stable(left_data) && $stable(right_data))); // R4

   AST_WAIT_NO_PAIR: assert property (@(posedge bclk) disable iff (!b_rst_n)
      !running |=> $stable(pair_tgl)); // R2

   AST_DISABLE_CLEARS: assert property (@(posedge bclk) disable iff (!b_rst_n)
      !en_b |=> (!running && sr_empty)); // R9

endmodule

bind stereo_serial_rx stereo_serial_rx_chk #(.DATA_W(DATA_W)) i_chk (
   .sys_clk    (sys_clk),
   .sys_rst_n  (sys_rst_n),
   .bclk       (bclk),
   .b_rst_n    (b_rst_n),
   .en_b       (en_b),
   .running    (running),
   .pair_tgl   (pair_tgl),
   .sr_empty   (sr_empty),
   .pair_valid (pair_valid),
   .left_data  (left_data),
   .right_data (right_data)
);

// File: tb/test_stereo_serial_rx.sv
module test_stereo_serial_rx;

   logic        sys_clk = 1'b0;
   logic        sys_rst_n = 1'b0;
   logic        glb_en = 1'b0;
   logic        chan_en = 1'b0;
   logic        fmt_delay = 1'b1;
   logic        fmt_rjust = 1'b0;
   logic        fmt_lsb_first = 1'b0;
   logic [1:0]  word_len = 2'd3;
   logic        bclk = 1'b0;
   logic        wclk = 1'b0;
   logic        sdata = 1'b0;
   logic [31:0] left_data;
   logic [31:0] right_data;
   logic        pair_valid;

   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;
   string       cur_req = "R10";
   logic [31:0] exp_l[$];
   logic [31:0] exp_r[$];
   bit          st_ch[$];
   bit          st_d[$];
   int          play_idx = 0;
   logic        pv_prev = 1'b0;
   logic [31:0] prev_l = '0;
   logic [31:0] prev_r = '0;

   always #10 sys_clk = ~sys_clk;   // 50 MHz
   always #40 bclk = ~bclk;

   stereo_serial_rx i_stereo_serial_rx (
      .sys_clk       (sys_clk),
      .sys_rst_n     (sys_rst_n),
      .glb_en        (glb_en),
      .chan_en       (chan_en),
      .fmt_delay     (fmt_delay),
      .fmt_rjust     (fmt_rjust),
      .fmt_lsb_first (fmt_lsb_first),
      .word_len      (word_len),
      .bclk          (bclk),
      .wclk          (wclk),
      .sdata         (sdata),
      .left_data     (left_data),
      .right_data    (right_data),
      .pair_valid    (pair_valid)
   );

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   function automatic int bits_of(input logic [1:0] code);
      case (code)
         2'd0: return 16;
         2'd1: return 20;
         2'd2: return 24;
         default: return 32;
      endcase
   endfunction

   function automatic logic [31:0] expect_word(input logic [31:0] w, input int n, input bit rj);
      logic [63:0] m;
      m = {32'd0, w} & ((64'd1 << n) - 64'd1);
      return rj ? m[31:0] : (m[31:0] << (32 - n));
   endfunction

   task automatic add_bits(input bit ch, input int cnt, input bit val);
      for (int i = 0; i < cnt; i++) begin
         st_ch.push_back(ch);
         st_d.push_back(val);
      end
   endtask

   task automatic add_slot(input bit ch, input logic [31:0] w, input int n, input bit lsb);
      for (int i = 0; i < 32; i++) begin
         st_ch.push_back(ch);
         if (i < n) st_d.push_back(lsb ? w[i] : w[n-1-i]);
         else       st_d.push_back(1'b1);   // surplus bits, must be dropped (R6)
      end
   endtask

   task automatic play(input bit dly);
      for (int k = 0; k < st_ch.size(); k++) begin
         @(negedge bclk);
         play_idx = k;
         sdata = st_d[k];
         wclk = (dly && (k + 1 < st_ch.size())) ? st_ch[k+1] : st_ch[k];
      end
      st_ch.delete();
      st_d.delete();
   endtask

   task automatic run_phase(input string req, input bit g, input bit c, input bit dly,
                            input bit rj, input bit lsb, input logic [1:0] wl,
                            input int nfr, input bit want, input bit mid_drop);
      int n;
      logic [31:0] l;
      logic [31:0] r;
      n = bits_of(wl);
      play_idx = 0;
      @(negedge sys_clk);
      cur_req = req;
      fmt_delay = dly;
      fmt_rjust = rj;
      fmt_lsb_first = lsb;
      word_len = wl;
      glb_en = g;
      chan_en = c;
      // Partial frame in progress at enable time: ignored (R2)
      add_bits(1'b0, 6, 1'b1);
      add_bits(1'b1, 8, 1'b1);
      for (int f = 0; f < nfr; f++) begin
         l = $urandom;
         r = $urandom;
         if (f == 0) begin
            l = l | 32'h8000_0001 | (32'd1 << (n - 1));
            r = r | 32'h8000_0001 | (32'd1 << (n - 1));
         end
         add_slot(1'b0, l, n, lsb);
         add_slot(1'b1, r, n, lsb);
         if (want && !(mid_drop && f == 1)) begin
            exp_l.push_back(expect_word(l, n, rj));
            exp_r.push_back(expect_word(r, n, rj));
         end
      end
      add_bits(1'b0, 8, 1'b0);
      if (mid_drop) begin
         fork
            play(dly);
            begin
               wait (play_idx == 14 + 64 + 10);
               @(negedge sys_clk);
               chan_en = 1'b0;   // R9 interrupt frame 2
               repeat (8) @(negedge bclk);
               @(negedge sys_clk);
               chan_en = 1'b1;
            end
         join
      end else begin
         play(dly);
      end
      repeat (40) @(negedge sys_clk);
      chk(exp_l.size() == 0, {req, " pairs outstanding at end of run"}, 32'(exp_l.size()), 32'd0);
      glb_en = 1'b0;
      chan_en = 1'b0;
      repeat (20) @(negedge sys_clk);
   endtask

   // Reference comparison on every system clock (R4, R3 and format checks)
   always @(negedge sys_clk) begin
      if (sys_rst_n && !done) begin
         if (pair_valid) begin
            if (pv_prev) chk(1'b0, "R4 strobe longer than one cycle", 32'd1, 32'd0);
            if (exp_l.size() == 0) begin
               chk(1'b0, {cur_req, " unexpected pair"}, left_data, 32'd0);
            end else begin
               logic [31:0] el;
               logic [31:0] er;
               el = exp_l.pop_front();
               er = exp_r.pop_front();
               chk(left_data == el, {cur_req, " R3 left word"}, left_data, el);
               chk(right_data == er, {cur_req, " R3 right word"}, right_data, er);
            end
         end else if (left_data != prev_l || right_data != prev_r) begin
            chk(1'b0, "R4 data moved without strobe", left_data, prev_l);
         end
         pv_prev = pair_valid;
         prev_l = left_data;
         prev_r = right_data;
      end
   end

   initial begin
      repeat (5) @(negedge sys_clk);
      chk(pair_valid == 1'b0, "R10 reset strobe", 32'(pair_valid), 32'd0);
      chk(left_data == '0, "R10 reset left", left_data, 32'd0);
      chk(right_data == '0, "R10 reset right", right_data, 32'd0);
      sys_rst_n = 1'b1;
      repeat (10) @(negedge sys_clk);

      run_phase("R2 R5 delayed msb-first 32", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 4, 1'b1, 1'b0);
      run_phase("R5 plain-edge R6 16 bits", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 4, 1'b1, 1'b0);
      run_phase("R7 right-justified R6 20 bits", 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 4, 1'b1, 1'b0);
      run_phase("R8 lsb-first R6 24 bits", 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd2, 4, 1'b1, 1'b0);
      run_phase("R8 R7 R5 lsb-first rjust plain-edge 16", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 4, 1'b1, 1'b0);
      run_phase("R1 controller disabled", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 3, 1'b0, 1'b0);
      run_phase("R9 channel disabled", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 3, 1'b0, 1'b0);
      run_phase("R9 R2 mid-frame disable", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 3, 1'b1, 1'b1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge sys_clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired in %s actual=running expected=finished", cur_req);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule